// File: doc/BRIEF.md
# Audio Ring-Buffer DMA Channel

This block is the data mover for one audio port. It has two independent lanes. The playback lane reads 32-bit words from a circular buffer in memory and passes them to an audio output stream. The capture lane takes words from an audio input stream and writes them into a second circular buffer. Software sets a buffer base address and a byte length for each lane. It then starts the lane by writing a shared control register. The current pass position of each lane can be read back at any time.

Each lane raises a one-cycle event when half of the buffer has been moved and another when all of it has. Each event also sets a sticky status flag. With the wrap option set, a lane returns to its base address after the last word and carries on. The buffer then works as a two-period ping-pong ring with no software action between periods. It runs until a halt is written. Without the wrap option, the lane goes idle after one pass. The memory side of each lane is a word request/acknowledge handshake. The audio side is a valid/ready stream.

Top module: `audio_ring_dma`

## Requirements
- R1: Register map (byte offsets): 0x00 playback base, 0x04 capture base, 0x08 playback length, 0x0C capture length, 0x10 control, 0x14 playback position, 0x18 capture position, 0x1C status. Bases read back as written. Lengths keep only bits 25:0. All registers read 0 after reset.
- R2: Control bits for playback are go at bit 0, halt at bit 1, wrap at bit 2 and alignment at bits 9:8. Capture uses bits 16, 17, 18 and 25:24. Wrap and alignment read back as written. Go and halt are write-one pulses. A go bit reads 1 while its lane is busy. Writing go to an idle lane starts it at the base with position 0. Writing go to a busy lane has no effect.
- R3: Playback fetches words from base + 4k, for k = 0, 1, 2, and so on. It presents each word on the output stream in that order. A memory request stays high until it is acknowledged.
- R4: Capture writes the k-th accepted input word to base + 4k, in order.
- R5: A half event pulses for exactly one cycle after the word that brings the pass position to length/2.
- R6: A full event pulses for exactly one cycle after the word that brings the position to the length. Without wrap, the lane then goes idle, its go bit reads 0 and the position register holds the length.
- R7: With wrap set, a full event restarts the lane at the base with position 0. Events repeat on every pass.
- R8: A halt stops its lane on the next clock, whatever the remaining length. It clears the go bit and issues no further requests. The position holds its value. A halt wins over a go in the same write.
- R9: Halting or starting one lane leaves the other lane's activity, position and control bits unchanged.
- R10: Status bits are 0 playback half, 1 playback full, 16 capture half and 17 capture full. Each is set by its event and held until software writes a 1 to that bit.
- R11: The position registers are read-only. Writes to 0x14 and 0x18 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| tx_mem_req | output | 1 | Playback memory read request |
| tx_mem_addr | output | 32 | Playback read byte address |
| tx_mem_ack | input | 1 | Playback read acknowledge |
| tx_mem_rdata | input | 32 | Playback read data |
| tx_out_valid | output | 1 | Output stream valid |
| tx_out_ready | input | 1 | Output stream ready |
| tx_out_data | output | 32 | Output stream word |
| rx_in_valid | input | 1 | Input stream valid |
| rx_in_ready | output | 1 | Input stream ready |
| rx_in_data | input | 32 | Input stream word |
| rx_mem_req | output | 1 | Capture memory write request |
| rx_mem_addr | output | 32 | Capture write byte address |
| rx_mem_wdata | output | 32 | Capture write data |
| rx_mem_ack | input | 1 | Capture write acknowledge |
| tx_half_evt | output | 1 | Playback half event pulse |
| tx_full_evt | output | 1 | Playback full event pulse |
| rx_half_evt | output | 1 | Capture half event pulse |
| rx_full_evt | output | 1 | Capture full event pulse |

## Verification
The hardest situation to reach is a halt that lands in the middle of a wrapping pass while the other lane keeps running. In that state the halt must not disturb the other lane's position, events or wrap bit. The stimulus starts both lanes in wrap mode over short buffers, so that several passes and their events happen within a few dozen cycles. It throttles the output stream, stalls it, and then halts playback. The halt is a read-modify-write of the control register that sends back a go bit for the busy capture lane. Capture must keep writing to wrapped addresses, and its events must keep lining up with the word count, until it too is stopped.

// File: rtl/ardma_pkg.sv
package ardma_pkg;

    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_FETCH = 2'd1,
        CH_DRAIN = 2'd2
    } ch_state_e;

    localparam int REG_AW = 5;

    localparam logic [REG_AW-1:0] OFS_BASE0   = 5'h00;
    localparam logic [REG_AW-1:0] OFS_TOTAL0  = 5'h08;
    localparam logic [REG_AW-1:0] OFS_CTRL    = 5'h10;
    localparam logic [REG_AW-1:0] OFS_MOVED0  = 5'h14;
    localparam logic [REG_AW-1:0] OFS_STATUS  = 5'h1C;

    localparam int LANES      = 2;
    localparam int LANE_SHIFT = 16;
    localparam int BIT_GO     = 0;
    localparam int BIT_HALT   = 1;
    localparam int BIT_WRAP   = 2;
    localparam int ALIGN_LSB  = 8;

endpackage

// File: rtl/ring_lane.sv
module ring_lane
    import ardma_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              reload_i,
    input  logic [DATA_W-1:0] base_i,
    input  logic [CNT_W-1:0]  total_i,
    output logic              src_req_o,
    input  logic              src_hs_i,
    input  logic [DATA_W-1:0] src_data_i,
    output logic              snk_req_o,
    input  logic              snk_hs_i,
    output logic [DATA_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o,
    output logic              busy_o,
    output logic [CNT_W-1:0]  moved_o,
    output logic              half_o,
    output logic              full_o
);

    localparam int STEP_BYTES = DATA_W / 8;

    typedef struct packed {
        ch_state_e         st;
        logic [CNT_W-1:0]  moved;
        logic [DATA_W-1:0] word;
        logic              half;
        logic              full;
    } lane_t;

    lane_t lane_d, lane_q;
    logic [CNT_W-1:0] moved_inc;
    logic [CNT_W-1:0] half_mark;

    always_comb begin
        moved_inc = lane_q.moved + CNT_W'(STEP_BYTES);
        half_mark = total_i >> 1;
        lane_d = lane_q;
        lane_d.half = 1'b0;
        lane_d.full = 1'b0;
        case (lane_q.st)
            CH_IDLE: begin
                if (start_i) begin
                    lane_d.st    = CH_FETCH;
                    lane_d.moved = '0;
                end
            end
            CH_FETCH: begin
                if (src_hs_i) begin
                    lane_d.word = src_data_i;
                    lane_d.st   = CH_DRAIN;
                end
            end
            CH_DRAIN: begin
                if (snk_hs_i) begin
                    lane_d.moved = moved_inc;
                    lane_d.half  = (moved_inc == half_mark);
                    lane_d.st    = CH_FETCH;
                    if (moved_inc == total_i) begin
                        lane_d.full = 1'b1;
                        if (reload_i) begin
                            lane_d.moved = '0;
                        end else begin
                            lane_d.st = CH_IDLE;
                        end
                    end
                end
            end
            default: lane_d.st = CH_IDLE;
        endcase
        if (stop_i) begin
            lane_d.st    = CH_IDLE;
            lane_d.moved = lane_q.moved;
            lane_d.half  = 1'b0;
            lane_d.full  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_q <= '0;
        end else begin
            lane_q <= lane_d;
        end
    end

    assign src_req_o = (lane_q.st == CH_FETCH);
    assign snk_req_o = (lane_q.st == CH_DRAIN);
    assign addr_o    = base_i + DATA_W'(lane_q.moved);
    assign data_o    = lane_q.word;
    assign busy_o    = (lane_q.st != CH_IDLE);
    assign moved_o   = lane_q.moved;
    assign half_o    = lane_q.half;
    assign full_o    = lane_q.full;

    // R8: a halt leaves the lane idle one clock later
    assert_halt_idles_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> !busy_o);

    // R5 / R6: half and full marks are distinct words
    assert_events_apart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(half_o && full_o));

    // R6: a pass without wrap ends idle
    assert_oneshot_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && !$past(reload_i)) |-> !busy_o);

    // R7: a pass with wrap restarts at position zero
    assert_wrap_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && $past(reload_i)) |-> (busy_o && moved_o == '0));

    // R3: a pending source request is held until served
    assert_src_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (src_req_o && !src_hs_i && !stop_i) |=> src_req_o);

    // R6: position stays inside the programmed length while running
    assert_moved_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (moved_o < total_i));

endmodule

// File: rtl/ring_regs.sv
module ring_regs
    import ardma_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 26
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_i,
    input  logic [REG_AW-1:0]             addr_i,
    input  logic [DATA_W-1:0]             wdata_i,
    output logic [DATA_W-1:0]             rdata_o,
    input  logic [LANES-1:0]              busy_i,
    input  logic [LANES-1:0][CNT_W-1:0]   moved_i,
    input  logic [LANES-1:0]              half_i,
    input  logic [LANES-1:0]              full_i,
    output logic [LANES-1:0]              start_o,
    output logic [LANES-1:0]              stop_o,
    output logic [LANES-1:0]              wrap_o,
    output logic [LANES-1:0][DATA_W-1:0]  base_o,
    output logic [LANES-1:0][CNT_W-1:0]   total_o
);

    typedef struct packed {
        logic [LANES-1:0][DATA_W-1:0] base;
        logic [LANES-1:0][CNT_W-1:0]  total;
        logic [LANES-1:0]             wrap;
        logic [LANES-1:0][1:0]        align;
        logic [LANES-1:0][1:0]        sticky;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  ctrl_hit;
    logic  stat_hit;
    logic [DATA_W-1:0] ctrl_view;
    logic [DATA_W-1:0] stat_view;

    always_comb begin
        regs_d   = regs_q;
        ctrl_hit = wr_i && (addr_i == OFS_CTRL);
        stat_hit = wr_i && (addr_i == OFS_STATUS);
        start_o  = '0;
        stop_o   = '0;
        for (int l = 0; l < LANES; l++) begin
            if (wr_i && addr_i == OFS_BASE0 + REG_AW'(4 * l)) begin
                regs_d.base[l] = wdata_i;
            end
            if (wr_i && addr_i == OFS_TOTAL0 + REG_AW'(4 * l)) begin
                regs_d.total[l] = wdata_i[CNT_W-1:0];
            end
            if (ctrl_hit) begin
                regs_d.wrap[l]  = wdata_i[LANE_SHIFT*l + BIT_WRAP];
                regs_d.align[l] = wdata_i[LANE_SHIFT*l + ALIGN_LSB +: 2];
            end
            start_o[l] = ctrl_hit && wdata_i[LANE_SHIFT*l + BIT_GO];
            stop_o[l]  = ctrl_hit && wdata_i[LANE_SHIFT*l + BIT_HALT];
            regs_d.sticky[l] = (regs_q.sticky[l]
                                & ~(stat_hit ? wdata_i[LANE_SHIFT*l +: 2] : 2'b00))
                               | {full_i[l], half_i[l]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        ctrl_view = '0;
        stat_view = '0;
        for (int l = 0; l < LANES; l++) begin
            ctrl_view[LANE_SHIFT*l + BIT_GO]         = busy_i[l];
            ctrl_view[LANE_SHIFT*l + BIT_WRAP]       = regs_q.wrap[l];
            ctrl_view[LANE_SHIFT*l + ALIGN_LSB +: 2] = regs_q.align[l];
            stat_view[LANE_SHIFT*l +: 2]             = regs_q.sticky[l];
        end
        case (addr_i)
            5'h00:      rdata_o = regs_q.base[0];
            5'h04:      rdata_o = regs_q.base[1];
            5'h08:      rdata_o = DATA_W'(regs_q.total[0]);
            5'h0C:      rdata_o = DATA_W'(regs_q.total[1]);
            OFS_CTRL:   rdata_o = ctrl_view;
            OFS_MOVED0: rdata_o = DATA_W'(moved_i[0]);
            5'h18:      rdata_o = DATA_W'(moved_i[1]);
            OFS_STATUS: rdata_o = stat_view;
            default:    rdata_o = '0;
        endcase
    end

    assign wrap_o  = regs_q.wrap;
    assign base_o  = regs_q.base;
    assign total_o = regs_q.total;

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_sticky_chk
            // R10: a full flag persists until a write-one clear
            assert_sticky_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
                (regs_q.sticky[g][1] && !(stat_hit && wdata_i[LANE_SHIFT*g + 1]))
                |=> regs_q.sticky[g][1]);
        end
    endgenerate

endmodule

// File: rtl/audio_ring_dma.sv
module audio_ring_dma
    import ardma_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [4:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              tx_mem_req,
    output logic [31:0]       tx_mem_addr,
    input  logic              tx_mem_ack,
    input  logic [31:0]       tx_mem_rdata,
    output logic              tx_out_valid,
    input  logic              tx_out_ready,
    output logic [31:0]       tx_out_data,
    input  logic              rx_in_valid,
    output logic              rx_in_ready,
    input  logic [31:0]       rx_in_data,
    output logic              rx_mem_req,
    output logic [31:0]       rx_mem_addr,
    output logic [31:0]       rx_mem_wdata,
    input  logic              rx_mem_ack,
    output logic              tx_half_evt,
    output logic              tx_full_evt,
    output logic              rx_half_evt,
    output logic              rx_full_evt
);

    logic [LANES-1:0]             start, stop, wrap, busy, half, full;
    logic [LANES-1:0]             src_req, src_hs, snk_req, snk_hs;
    logic [LANES-1:0][DATA_W-1:0] base, src_data, addr, data;
    logic [LANES-1:0][CNT_W-1:0]  total, moved;

    ring_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (reg_wr),
        .addr_i  (reg_addr),
        .wdata_i (reg_wdata),
        .rdata_o (reg_rdata),
        .busy_i  (busy),
        .moved_i (moved),
        .half_i  (half),
        .full_i  (full),
        .start_o (start),
        .stop_o  (stop),
        .wrap_o  (wrap),
        .base_o  (base),
        .total_o (total)
    );

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            ring_lane #(.DATA_W(DATA_W), .CNT_W(CNT_W)) lane_i (
                .clk        (clk),
                .rst_n      (rst_n),
                .start_i    (start[g]),
                .stop_i     (stop[g]),
                .reload_i   (wrap[g]),
                .base_i     (base[g]),
                .total_i    (total[g]),
                .src_req_o  (src_req[g]),
                .src_hs_i   (src_hs[g]),
                .src_data_i (src_data[g]),
                .snk_req_o  (snk_req[g]),
                .snk_hs_i   (snk_hs[g]),
                .addr_o     (addr[g]),
                .data_o     (data[g]),
                .busy_o     (busy[g]),
                .moved_o    (moved[g]),
                .half_o     (half[g]),
                .full_o     (full[g])
            );
        end
    endgenerate

    // playback: memory is the source, output stream is the sink
    assign tx_mem_req   = src_req[0];
    assign tx_mem_addr  = addr[0];
    assign src_hs[0]    = tx_mem_ack;
    assign src_data[0]  = tx_mem_rdata;
    assign tx_out_valid = snk_req[0];
    assign tx_out_data  = data[0];
    assign snk_hs[0]    = snk_req[0] && tx_out_ready;

    // capture: input stream is the source, memory is the sink
    assign rx_in_ready  = src_req[1];
    assign src_hs[1]    = src_req[1] && rx_in_valid;
    assign src_data[1]  = rx_in_data;
    assign rx_mem_req   = snk_req[1];
    assign rx_mem_addr  = addr[1];
    assign rx_mem_wdata = data[1];
    assign snk_hs[1]    = rx_mem_ack;

    assign tx_half_evt = half[0];
    assign tx_full_evt = full[0];
    assign rx_half_evt = half[1];
    assign rx_full_evt = full[1];

endmodule

// File: tb/audio_ring_dma_tb_top.sv
module audio_ring_dma_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tx_mem_req;
    logic [31:0] tx_mem_addr;
    logic        tx_mem_ack = 1'b0;
    logic [31:0] tx_mem_rdata = '0;
    logic        tx_out_valid;
    logic        tx_out_ready = 1'b0;
    logic [31:0] tx_out_data;
    logic        rx_in_valid = 1'b0;
    logic        rx_in_ready;
    logic [31:0] rx_in_data = '0;
    logic        rx_mem_req;
    logic [31:0] rx_mem_addr;
    logic [31:0] rx_mem_wdata;
    logic        rx_mem_ack = 1'b0;
    logic        tx_half_evt, tx_full_evt, rx_half_evt, rx_full_evt;

    always #2.5 clk = ~clk;

    audio_ring_dma dut_i (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_mem_req(tx_mem_req), .tx_mem_addr(tx_mem_addr), .tx_mem_ack(tx_mem_ack),
        .tx_mem_rdata(tx_mem_rdata),
        .tx_out_valid(tx_out_valid), .tx_out_ready(tx_out_ready), .tx_out_data(tx_out_data),
        .rx_in_valid(rx_in_valid), .rx_in_ready(rx_in_ready), .rx_in_data(rx_in_data),
        .rx_mem_req(rx_mem_req), .rx_mem_addr(rx_mem_addr), .rx_mem_wdata(rx_mem_wdata),
        .rx_mem_ack(rx_mem_ack),
        .tx_half_evt(tx_half_evt), .tx_full_evt(tx_full_evt),
        .rx_half_evt(rx_half_evt), .rx_full_evt(rx_full_evt)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0] mem [64];
    logic [31:0] tx_exp [$];
    logic [31:0] rx_sent [$];

    bit tx_snk_en = 1'b0;
    bit rx_src_en = 1'b0;
    int tx_words = 0, tx_halves = 0, tx_fulls = 0, tx_tw = 8;
    int rx_words = 0, rx_halves = 0, rx_fulls = 0, rx_tw = 4;
    logic [31:0] tx_base_b = 32'h40;
    logic [31:0] rx_base_b = 32'h80;
    int rx_seq = 0;
    bit rx_pend = 1'b0;
    int cyc = 0;

    function automatic int widx(input logic [31:0] a);
        return int'((a >> 2) & 32'h3F);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wr = 1'b0;
        #1 d = reg_rdata;
    endtask

    // driver side of the scoreboard: expected playback words in order
    task automatic push_tx(input logic [31:0] base, input int tw, input int n);
        for (int k = 0; k < n; k++) tx_exp.push_back(mem[widx(base + 32'(4 * (k % tw)))]);
    endtask

    // monitor and responders, all acting at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (rst_n) begin
                if (tx_half_evt) begin
                    tx_halves++;
                    chk(tx_words % tx_tw == tx_tw / 2, "R5 tx half position", 32'(tx_words), 32'(tx_tw / 2));
                end
                if (tx_full_evt) begin
                    tx_fulls++;
                    chk(tx_words > 0 && tx_words % tx_tw == 0, "R6 tx full position", 32'(tx_words), 32'(tx_tw));
                end
                if (rx_half_evt) begin
                    rx_halves++;
                    chk(rx_words % rx_tw == rx_tw / 2, "R5 rx half position", 32'(rx_words), 32'(rx_tw / 2));
                end
                if (rx_full_evt) begin
                    rx_fulls++;
                    chk(rx_words > 0 && rx_words % rx_tw == 0, "R7 rx full position", 32'(rx_words), 32'(rx_tw));
                end
            end
            // playback memory
            tx_mem_ack = tx_mem_req;
            tx_mem_rdata = mem[widx(tx_mem_addr)];
            if (tx_mem_req)
                chk(tx_mem_addr == tx_base_b + 32'(4 * (tx_words % tx_tw)), "R3 tx fetch address",
                    tx_mem_addr, tx_base_b + 32'(4 * (tx_words % tx_tw)));
            // playback stream sink
            tx_out_ready = tx_snk_en && (cyc % 3 != 2);
            if (tx_out_valid && tx_out_ready) begin
                if (tx_exp.size() == 0) begin
                    chk(1'b0, "R3 tx unexpected word", tx_out_data, 32'h0);
                end else begin
                    logic [31:0] e;
                    e = tx_exp.pop_front();
                    chk(tx_out_data == e, "R3 tx stream word", tx_out_data, e);
                end
                tx_words++;
            end
            // capture stream source
            if (rx_pend) rx_seq++;
            rx_in_valid = rx_src_en;
            rx_in_data  = 32'h5A00_0000 + 32'(rx_seq);
            rx_pend = rx_in_valid && rx_in_ready;
            if (rx_pend) rx_sent.push_back(rx_in_data);
            // capture memory
            rx_mem_ack = rx_mem_req;
            if (rx_mem_req) begin
                chk(rx_mem_addr == rx_base_b + 32'(4 * (rx_words % rx_tw)), "R4 rx write address",
                    rx_mem_addr, rx_base_b + 32'(4 * (rx_words % rx_tw)));
                if (rx_sent.size() == 0) begin
                    chk(1'b0, "R4 rx write without input", rx_mem_wdata, 32'h0);
                end else begin
                    logic [31:0] e;
                    e = rx_sent.pop_front();
                    chk(rx_mem_wdata == e, "R4 rx write data", rx_mem_wdata, e);
                end
                rx_words++;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic wait_tx(input int n);
        for (int t = 0; t < 5000 && tx_words < n; t++) @(negedge clk);
    endtask

    task automatic wait_rx(input int n);
        for (int t = 0; t < 5000 && rx_words < n; t++) @(negedge clk);
    endtask

    task automatic quiet_tx(input string req, input int n);
        bit seen = 1'b0;
        for (int t = 0; t < n; t++) begin
            @(negedge clk);
            if (tx_mem_req || tx_out_valid) seen = 1'b1;
        end
        chk(!seen, req, 32'(seen), 32'h0);
    endtask

    initial begin
        logic [31:0] v;
        int w;
        for (int i = 0; i < 64; i++) mem[i] = 32'hA500_0000 + 32'(i * 7);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // reset state
        for (int a = 0; a < 8; a++) begin
            reg_read(5'(4 * a), v);
            chk(v == 32'h0, "R1 reset value", v, 32'h0);
        end

        // register map
        reg_write(5'h00, tx_base_b);
        reg_read(5'h00, v); chk(v == tx_base_b, "R1 tx base readback", v, tx_base_b);
        reg_write(5'h08, 32'hFFFF_FFFF);
        reg_read(5'h08, v); chk(v == 32'h03FF_FFFF, "R1 length width", v, 32'h03FF_FFFF);
        reg_write(5'h08, 32'd32);
        reg_write(5'h10, 32'h0200_0100);
        reg_read(5'h10, v); chk(v == 32'h0200_0100, "R2 align readback", v, 32'h0200_0100);
        reg_write(5'h14, 32'h1234_5678);
        reg_read(5'h14, v); chk(v == 32'h0, "R11 position write ignored", v, 32'h0);

        // one-shot playback of 8 words
        tx_tw = 8;
        push_tx(tx_base_b, 8, 8);
        tx_snk_en = 1'b1;
        reg_write(5'h10, 32'h0200_0101);
        reg_read(5'h10, v); chk(v[0] == 1'b1, "R2 go reads busy", v, 32'h0200_0101);
        wait_tx(8);
        repeat (3) @(negedge clk);
        reg_read(5'h10, v); chk(v[0] == 1'b0, "R6 one-shot idle", v, 32'h0200_0100);
        reg_read(5'h14, v); chk(v == 32'd32, "R6 position holds length", v, 32'd32);
        chk(tx_halves == 1, "R5 one half event", 32'(tx_halves), 32'd1);
        chk(tx_fulls == 1, "R6 one full event", 32'(tx_fulls), 32'd1);
        chk(tx_exp.size() == 0, "R3 all words delivered", 32'(tx_exp.size()), 32'h0);
        quiet_tx("R6 no activity after one-shot", 10);

        // sticky status
        reg_read(5'h1C, v); chk(v == 32'h3, "R10 status set", v, 32'h3);
        reg_write(5'h1C, 32'h1);
        reg_read(5'h1C, v); chk(v == 32'h2, "R10 clear half only", v, 32'h2);
        reg_write(5'h1C, 32'h2);
        reg_read(5'h1C, v); chk(v == 32'h0, "R10 clear full", v, 32'h0);

        // both lanes wrapping, then halt playback only
        tx_words = 0; tx_halves = 0; tx_fulls = 0; tx_tw = 4;
        rx_words = 0; rx_halves = 0; rx_fulls = 0; rx_tw = 4;
        reg_write(5'h08, 32'd16);
        reg_write(5'h04, rx_base_b);
        reg_write(5'h0C, 32'd16);
        push_tx(tx_base_b, 4, 40);
        rx_src_en = 1'b1;
        reg_write(5'h10, 32'h0005_0005);
        wait_tx(10);
        tx_snk_en = 1'b0;
        repeat (3) @(negedge clk);
        reg_read(5'h10, v);
        chk(v == 32'h0005_0005, "R2 both lanes busy with wrap", v, 32'h0005_0005);
        reg_write(5'h10, v | 32'h2);
        w = tx_words;
        tx_exp.delete();
        reg_read(5'h10, v);
        chk(v == 32'h0005_0004, "R9 capture untouched by playback halt", v, 32'h0005_0004);
        reg_read(5'h14, v);
        chk(v == 32'(4 * (w % 4)), "R8 position holds after halt", v, 32'(4 * (w % 4)));
        chk(tx_fulls == w / 4, "R7 tx full per pass", 32'(tx_fulls), 32'(w / 4));
        chk(tx_halves == (w + 2) / 4, "R7 tx half per pass", 32'(tx_halves), 32'((w + 2) / 4));
        tx_snk_en = 1'b1;
        quiet_tx("R8 playback quiet after halt", 10);
        tx_snk_en = 1'b0;

        wait_rx(12);
        rx_src_en = 1'b0;
        repeat (4) @(negedge clk);
        chk(rx_fulls == rx_words / 4 && rx_fulls >= 3, "R7 rx passes", 32'(rx_fulls), 32'(rx_words / 4));
        chk(rx_halves == (rx_words + 2) / 4, "R7 rx halves", 32'(rx_halves), 32'((rx_words + 2) / 4));
        reg_read(5'h10, v);
        reg_write(5'h10, v | 32'h0002_0000);
        reg_read(5'h10, v); chk(v[16] == 1'b0, "R8 capture halted", v, 32'h0004_0004);
        reg_read(5'h18, v);
        chk(v == 32'(4 * (rx_words % 4)), "R8 rx position holds", v, 32'(4 * (rx_words % 4)));
        chk(rx_sent.size() == 0, "R4 every input word stored", 32'(rx_sent.size()), 32'h0);
        rx_src_en = 1'b1;
        begin
            bit seen = 1'b0;
            for (int t = 0; t < 10; t++) begin
                @(negedge clk);
                if (rx_mem_req || rx_in_ready) seen = 1'b1;
            end
            chk(!seen, "R8 capture quiet after halt", 32'(seen), 32'h0);
        end
        rx_src_en = 1'b0;

        // halt wins over go
        reg_write(5'h10, 32'h0000_0003);
        reg_read(5'h10, v); chk(v[0] == 1'b0, "R8 halt beats go", v, 32'h0);
        quiet_tx("R8 no start on go with halt", 8);

        // go while busy is ignored
        tx_words = 0; tx_halves = 0; tx_fulls = 0; tx_tw = 8;
        reg_write(5'h08, 32'd32);
        push_tx(tx_base_b, 8, 8);
        reg_write(5'h10, 32'h0000_0001);
        reg_read(5'h14, v); chk(v == 32'h0, "R2 start at position zero", v, 32'h0);
        tx_snk_en = 1'b1;
        wait_tx(2);
        tx_snk_en = 1'b0;
        repeat (3) @(negedge clk);
        w = tx_words;
        reg_write(5'h10, 32'h0000_0001);
        reg_read(5'h14, v);
        chk(v == 32'(4 * w), "R2 go while busy ignored", v, 32'(4 * w));
        tx_snk_en = 1'b1;
        wait_tx(8);
        repeat (3) @(negedge clk);
        chk(tx_fulls == 1 && tx_exp.size() == 0, "R6 pass completes once", 32'(tx_fulls), 32'd1);
        reg_read(5'h14, v); chk(v == 32'd32, "R6 final position", v, 32'd32);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule